// File: doc/BRIEF.md
# Streaming Block Programmer With Automatic Line Advance

This block runs a factory-style programming session over one erase block of a word-addressed array. The host opens the session with a two-write command pair aimed at the start address. From then on it sends no further commands, counts or addresses. It streams raw data words, 32 per buffer, and polls a busy bit between buffers. The data-write address is not used, except to recognise the exit command.

Each time the buffer is full, the sequencer writes the 32 words to consecutive array locations, starting at its own line pointer. It reads each word back at once and compares it with the buffered value. When the line is done, the pointer moves to the next 32-word line. The session ends in any of three ways: the host writes the exit pattern, a readback mismatch occurs, or the last line of the block has been programmed. In every case the sequencer passes through a one-cycle exit phase before it reports ready again.

The array sits outside the block. It is reached through a write strobe, an address, write data and a combinational readback word. Block write protection comes in as one lock bit per erase block.

Top module: `fbp_programmer`

## Requirements
- R1: After reset the status byte reads 0x80 (bit 7 = ready, bit 4 = error, bit 0 = buffer busy) and no array write occurs.
- R2: A write of 0x80 followed by a write of 0xD0 to the same address opens a session when that address is 32-word aligned and its block is not locked. The status reads 0x00 after each of the two writes.
- R3: The session fails to open, and the status reads 0x90 with no array write, in any of these cases: the address is misaligned, the block is locked, the second write is not 0xD0, or the second write goes to a different address.
- R4: Every buffer takes exactly 32 accepted host writes, and the address of those writes is ignored. The status stays 0x00 after the 31st write and reads 0x01 after the 32nd.
- R5: Host writes made while bit 0 is set are ignored. They change neither the buffered data nor the fill count.
- R6: Buffer word k goes to line base + k. Each word takes one write cycle followed by one readback cycle, so bit 0 stays set for exactly 64 cycles per buffer.
- R7: After a buffer finishes, the line pointer moves on by 32 words and the status returns to 0x00. When that buffer was the block's last line, the status reads 0x00 for one exit cycle and then 0x80.
- R8: A readback mismatch stops programming at once and sets bit 4. The status reads 0x10 for one exit cycle and then 0x90.
- R9: An all-ones write whose block bits differ from the session block, made while no word of the current buffer is loaded, ends the session: 0x00 for one cycle, then 0x80. An all-ones write inside the block, or made after some words of the buffer are loaded, is taken as data.
- R10: In the ready state, a write of 0x50 clears bit 4. Any other ready-state write except 0x80 has no effect on the status and causes no array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe, one word per cycle |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| blk_lock | input | NUM_BLK | Per-block write protection |
| status | output | 8 | Status byte: bit 7 ready, bit 4 error, bit 0 busy |
| arr_we | output | 1 | Array word write strobe |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | DATA_W | Array write data |
| arr_rdata | input | DATA_W | Array readback of arr_addr, combinational |

## Verification
The assertions rely on three assumptions about the inputs. First, the array returns the word at arr_addr in the same cycle, so the readback compare sees the value just written. Second, the host drives at most one write per cycle. Third, reset is held long enough to clear the status before the first check. The bench drives its own array model with a combinational read and an optional corrupted address. It issues every host write from a single task that holds the strobe for exactly one cycle. It sweeps every block and every start line of a small configuration and computes each expected array word from its address.

// File: rtl/fbp_pkg.sv
// Shared types and codes for the streaming block programmer.
// Assumes command codes fit in the low byte of the host data word.
package fbp_pkg;

    typedef enum logic [2:0] {
        ST_READY,
        ST_SETUP,
        ST_LOAD,
        ST_PROG,
        ST_EXIT
    } fbp_state_t;

    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;

    localparam int unsigned SR_READY = 7;
    localparam int unsigned SR_ERROR = 4;
    localparam int unsigned SR_BUSY  = 0;

endpackage

// File: rtl/fbp_line_buffer.sv
// One-line write buffer: stores 2**LINE_W data words filled by index.
// Assumes a single writer and a combinational read port for the sequencer.
module fbp_line_buffer #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LINE_W = 5
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LINE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << LINE_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Capture one host data word per accepted write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_idx] <= wr_data;
        end
    end

    // Present the word being programmed or verified.
    assign rd_data = words[rd_idx];

endmodule

// File: rtl/fbp_addr_gen.sv
// Line pointer for the session: loaded with the aligned start address,
// advanced by one 32-word line after each programmed buffer.
// Assumes the start address is aligned (checked by the sequencer).
module fbp_addr_gen #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BLK_W  = 8,
    parameter int unsigned LINE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              advance,
    input  logic [LINE_W-1:0] word_idx,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_line
);
    localparam int unsigned LINE_BITS = ADDR_W - LINE_W;
    localparam int unsigned LPB_W     = BLK_W - LINE_W;

    logic [LINE_BITS-1:0] line_q;

    // Hold the current line number; load at session start, step per buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (load) begin
            line_q <= start_addr[ADDR_W-1:LINE_W];
        end else if (advance) begin
            line_q <= line_q + 1'b1;
        end
    end

    // Word address is the line number joined with the word index.
    assign cur_addr  = {line_q, word_idx};

    // The last line of a block has all line-in-block bits set.
    assign last_line = &line_q[LPB_W-1:0];

endmodule

// File: rtl/fbp_seq_ctrl.sv
// Session sequencer: command decode, buffer fill count, program/verify
// stepping and status generation.
// Assumes one host write per cycle and same-cycle array readback.
module fbp_seq_ctrl
    import fbp_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned BLK_W   = 8,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned LINE_W  = 5,
    parameter int unsigned NUM_BLK = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [NUM_BLK-1:0] blk_lock,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [DATA_W-1:0] buf_word,
    input  logic              last_line,
    output logic              buf_we,
    output logic [LINE_W-1:0] fill_idx,
    output logic [LINE_W-1:0] word_idx,
    output logic              ag_load,
    output logic              ag_advance,
    output logic              arr_we,
    output logic [7:0]        status
);
    localparam int unsigned BLK_ID_W = ADDR_W - BLK_W;
    localparam logic [LINE_W-1:0] LAST_IDX = '1;

    fbp_state_t        state_q;
    logic [ADDR_W-1:0] setup_addr_q;
    logic              err_q;
    logic [LINE_W-1:0] fill_q;
    logic [LINE_W-1:0] widx_q;
    logic              verify_q;

    logic              is_setup_cmd;
    logic              is_confirm_cmd;
    logic              is_clear_cmd;
    logic              confirm_ok;
    logic              exit_hit;
    logic              mismatch;
    logic              line_done;
    logic [BLK_ID_W-1:0] host_blk;
    logic [BLK_ID_W-1:0] sess_blk;

    // Decode command words from the host data bus.
    always_comb begin
        is_setup_cmd   = (host_wdata == DATA_W'(CMD_SETUP));
        is_confirm_cmd = (host_wdata == DATA_W'(CMD_CONFIRM));
        is_clear_cmd   = (host_wdata == DATA_W'(CMD_CLEAR));
    end

    // Qualify the confirm write: same address, aligned, block writable.
    always_comb begin
        host_blk   = host_addr[ADDR_W-1:BLK_W];
        sess_blk   = setup_addr_q[ADDR_W-1:BLK_W];
        confirm_ok = is_confirm_cmd
                   && (host_addr == setup_addr_q)
                   && (host_addr[LINE_W-1:0] == '0)
                   && !blk_lock[host_blk];
    end

    // Exit pattern: all ones aimed outside the session block, buffer empty.
    always_comb begin
        exit_hit = (host_wdata == '1) && (host_blk != sess_blk) && (fill_q == '0);
    end

    // Verify compare and end-of-line detection during the readback cycle.
    always_comb begin
        mismatch  = (arr_rdata != buf_word);
        line_done = verify_q && (widx_q == LAST_IDX);
    end

    // Main state machine and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_READY;
            setup_addr_q <= '0;
            err_q        <= 1'b0;
            fill_q       <= '0;
            widx_q       <= '0;
            verify_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_READY: begin
                    if (host_we) begin
                        if (is_setup_cmd) begin
                            setup_addr_q <= host_addr;
                            state_q      <= ST_SETUP;
                        end else if (is_clear_cmd) begin
                            err_q <= 1'b0;
                        end
                    end
                end
                ST_SETUP: begin
                    if (host_we) begin
                        if (confirm_ok) begin
                            fill_q  <= '0;
                            state_q <= ST_LOAD;
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= ST_READY;
                        end
                    end
                end
                ST_LOAD: begin
                    if (host_we) begin
                        if (exit_hit) begin
                            state_q <= ST_EXIT;
                        end else begin
                            fill_q <= fill_q + 1'b1;
                            if (fill_q == LAST_IDX) begin
                                widx_q   <= '0;
                                verify_q <= 1'b0;
                                state_q  <= ST_PROG;
                            end
                        end
                    end
                end
                ST_PROG: begin
                    if (!verify_q) begin
                        verify_q <= 1'b1;
                    end else begin
                        verify_q <= 1'b0;
                        if (mismatch) begin
                            err_q   <= 1'b1;
                            state_q <= ST_EXIT;
                        end else if (line_done) begin
                            fill_q  <= '0;
                            state_q <= last_line ? ST_EXIT : ST_LOAD;
                        end else begin
                            widx_q <= widx_q + 1'b1;
                        end
                    end
                end
                ST_EXIT: begin
                    state_q <= ST_READY;
                end
                default: begin
                    state_q <= ST_READY;
                end
            endcase
        end
    end

    // Strobes to the buffer, the line pointer and the array.
    always_comb begin
        buf_we     = (state_q == ST_LOAD) && host_we && !exit_hit;
        ag_load    = (state_q == ST_SETUP) && host_we && confirm_ok;
        ag_advance = (state_q == ST_PROG) && line_done && !mismatch && !last_line;
        arr_we     = (state_q == ST_PROG) && !verify_q;
        fill_idx   = fill_q;
        word_idx   = widx_q;
    end

    // Assemble the status byte.
    always_comb begin
        status           = '0;
        status[SR_READY] = (state_q == ST_READY);
        status[SR_ERROR] = err_q;
        status[SR_BUSY]  = (state_q == ST_PROG);
    end

endmodule

// File: rtl/fbp_programmer.sv
// Top of the streaming block programmer: ties the sequencer, the line
// buffer and the line pointer to the host bus and the array port.
// Assumes the array read is combinational on arr_addr.
module fbp_programmer #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned BLK_W   = 8,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned LINE_W  = 5,
    parameter int unsigned NUM_BLK = 1 << (ADDR_W - BLK_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic [NUM_BLK-1:0] blk_lock,
    output logic [7:0]         status,
    output logic               arr_we,
    output logic [ADDR_W-1:0]  arr_addr,
    output logic [DATA_W-1:0]  arr_wdata,
    input  logic [DATA_W-1:0]  arr_rdata
);
    logic              buf_we;
    logic [LINE_W-1:0] fill_idx;
    logic [LINE_W-1:0] word_idx;
    logic [DATA_W-1:0] buf_word;
    logic              ag_load;
    logic              ag_advance;
    logic              last_line;

    fbp_seq_ctrl #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W),
        .DATA_W (DATA_W),
        .LINE_W (LINE_W),
        .NUM_BLK(NUM_BLK)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .blk_lock  (blk_lock),
        .arr_rdata (arr_rdata),
        .buf_word  (buf_word),
        .last_line (last_line),
        .buf_we    (buf_we),
        .fill_idx  (fill_idx),
        .word_idx  (word_idx),
        .ag_load   (ag_load),
        .ag_advance(ag_advance),
        .arr_we    (arr_we),
        .status    (status)
    );

    fbp_line_buffer #(
        .DATA_W(DATA_W),
        .LINE_W(LINE_W)
    ) u_buf (
        .clk    (clk),
        .wr_en  (buf_we),
        .wr_idx (fill_idx),
        .wr_data(host_wdata),
        .rd_idx (word_idx),
        .rd_data(buf_word)
    );

    fbp_addr_gen #(
        .ADDR_W(ADDR_W),
        .BLK_W (BLK_W),
        .LINE_W(LINE_W)
    ) u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ag_load),
        .start_addr(host_addr),
        .advance   (ag_advance),
        .word_idx  (word_idx),
        .cur_addr  (arr_addr),
        .last_line (last_line)
    );

    // The array is always fed the buffered word under the current index.
    assign arr_wdata = buf_word;

endmodule

// File: rtl/fbp_programmer_chk.sv
// Checker for fbp_programmer: temporal rules on status and array strobes.
// Assumes synchronous reset held at least one clock before checking.
module fbp_programmer_chk
    import fbp_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LINE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [DATA_W-1:0] host_wdata,
    input logic [7:0]        status,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        status[SR_BUSY] |-> !status[SR_READY]); // R6
    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> status[SR_BUSY]); // R6
    AST_WRITE_THEN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we); // R6
    AST_SEQUENTIAL_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we, 2)) |-> (arr_addr == ADDR_W'($past(arr_addr, 2) + 1'b1))); // R6
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SR_BUSY]) |-> (arr_we && (arr_addr[LINE_W-1:0] == '0))); // R7
    AST_ERROR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SR_ERROR]) |-> !status[SR_BUSY]); // R8
    AST_ERROR_CLEAR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[SR_ERROR]) |-> ($past(host_we) && $past(status[SR_READY])
                                     && ($past(host_wdata) == DATA_W'(CMD_CLEAR)))); // R10
endmodule

bind fbp_programmer fbp_programmer_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LINE_W(LINE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_wdata(host_wdata),
    .status    (status),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr)
);

// File: tb/fbp_programmer_test.sv
module fbp_programmer_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;
    localparam int BW = 7;
    localparam int DW = 16;
    localparam int LW = 5;
    localparam int NB = 1 << (AW - BW);
    localparam int WORDS = 1 << AW;
    localparam int BLKSZ = 1 << BW;
    localparam int LINES = BLKSZ / 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [NB-1:0] blk_lock = 4'b0100;
    logic [7:0] status;
    logic arr_we;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;
    logic [DW-1:0] arr_rdata;

    logic [DW-1:0] mem [WORDS];
    logic erase_req = 1'b0;
    int bad_addr = -1;
    int wr_count = 0;
    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbp_programmer #(.ADDR_W(AW), .BLK_W(BW), .DATA_W(DW), .LINE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .blk_lock(blk_lock), .status(status),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_rdata(arr_rdata)
    );

    // Array model: erase on request, optional corrupted address.
    always @(posedge clk) begin
        if (erase_req) begin
            for (int a = 0; a < WORDS; a++) mem[a] <= 16'hFFFF;
        end else if (arr_we) begin
            mem[arr_addr] <= (int'(arr_addr) == bad_addr) ? ~arr_wdata : arr_wdata;
            wr_count <= wr_count + 1;
        end
    end
    assign arr_rdata = mem[arr_addr];

    function automatic logic [15:0] pat(int a, int seed);
        return 16'((a * 40503 + seed * 7919) ^ (a << 4));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        host_we = 1'b1;
        host_addr = AW'(a);
        host_wdata = DW'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic erase();
        erase_req = 1'b1;
        tick();
        erase_req = 1'b0;
    endtask

    task automatic busy_count(output int cnt);
        cnt = 0;
        while (status[0] && cnt < 300) begin
            cnt++;
            tick();
        end
    endtask

    task automatic check_mem(string tag, int lo, int hi, int seed);
        int bad = 0;
        int first = 0;
        for (int a = 0; a < WORDS; a++) begin
            logic [15:0] e = (a >= lo && a < hi) ? pat(a, seed) : 16'hFFFF;
            if (mem[a] !== e) begin
                if (bad == 0) first = a;
                bad++;
            end
        end
        chk(bad == 0, tag, bad, 0);
        if (bad != 0) $display("  first mismatching word at %0d", first);
    endtask

    task automatic run_session(int blk, int sl, int seed);
        int start = blk * BLKSZ + sl * 32;
        int wc0;
        int cnt;
        erase();
        wc0 = wr_count;
        wr(start, 16'h0080);
        chk(status == 8'h00, "R2 setup pending", status, 8'h00);
        wr(start, 16'h00D0);
        if (blk_lock[blk]) begin
            chk(status == 8'h90, "R3 locked block refused", status, 8'h90);
            chk(wr_count == wc0, "R3 no array write", wr_count - wc0, 0);
            wr(0, 16'h0050);
            chk(status == 8'h80, "R10 clear after refusal", status, 8'h80);
            return;
        end
        chk(status == 8'h00, "R2 session open", status, 8'h00);
        for (int line = sl; line < LINES; line++) begin
            for (int k = 0; k < 32; k++) begin
                wr(blk * BLKSZ + ((k * 37) % BLKSZ), pat(blk * BLKSZ + line * 32 + k, seed));
                if (k == 30) chk(status == 8'h00, "R4 not full at 31", status, 8'h00);
            end
            chk(status == 8'h01, "R4 busy after 32nd word", status, 8'h01);
            busy_count(cnt);
            chk(cnt == 64, "R6 busy length", cnt, 64);
            chk(status == 8'h00, "R7 line finished", status, 8'h00);
            if (line == LINES - 1) begin
                tick();
                chk(status == 8'h80, "R7 ready after last line", status, 8'h80);
            end
        end
        check_mem("R6 R7 array contents", start, blk * BLKSZ + BLKSZ, seed);
    endtask

    initial begin
        int cnt;
        int wc0;
        repeat (3) tick();
        rst_n = 1'b1;
        chk(status == 8'h80, "R1 reset status", status, 8'h80);
        tick();
        chk(wr_count == 0, "R1 no array write", wr_count, 0);

        // Sweep every block and start line.
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < LINES; s++)
                run_session(b, s, b * 4 + s + 1);

        // R3: misaligned start, wrong confirm code, wrong confirm address.
        wc0 = wr_count;
        wr(3, 16'h0080); wr(3, 16'h00D0);
        chk(status == 8'h90, "R3 misaligned", status, 8'h90);
        wr(0, 16'h0050);
        wr(0, 16'h0080); wr(0, 16'h0012);
        chk(status == 8'h90, "R3 bad confirm code", status, 8'h90);
        wr(0, 16'h0050);
        wr(0, 16'h0080); wr(32, 16'h00D0);
        chk(status == 8'h90, "R3 confirm address differs", status, 8'h90);
        chk(wr_count == wc0, "R3 no array write", wr_count - wc0, 0);
        wr(0, 16'h0050);
        chk(status == 8'h80, "R10 clear", status, 8'h80);

        // R9: all-ones as data, then as exit.
        erase();
        wr(0, 16'h0080); wr(0, 16'h00D0);
        wr(5, 16'hFFFF);
        wr(200, 16'h1111);
        wr(300, 16'hFFFF);
        for (int k = 3; k < 32; k++) begin
            wr(7, pat(k, 99));
            if (k == 30) chk(status == 8'h00, "R9 all-ones counted as data", status, 8'h00);
        end
        chk(status == 8'h01, "R9 buffer full with all-ones words", status, 8'h01);
        busy_count(cnt);
        chk(mem[1] == 16'h1111 && mem[3] == pat(3, 99) && mem[31] == pat(31, 99),
            "R9 data placement", mem[3], pat(3, 99));
        wr(300, 16'hFFFF);
        chk(status == 8'h00, "R9 exit cycle", status, 8'h00);
        tick();
        chk(status == 8'h80, "R9 ready after exit", status, 8'h80);

        // R5: writes during busy ignored.
        erase();
        wr(160, 16'h0080); wr(160, 16'h00D0);
        for (int k = 0; k < 32; k++) wr(130, pat(160 + k, 5));
        wr(160, 16'h1234); wr(161, 16'h1234); wr(162, 16'h1234);
        busy_count(cnt);
        chk(cnt + 3 == 64, "R5 busy unaffected", cnt + 3, 64);
        for (int k = 0; k < 32; k++) begin
            wr(130, pat(192 + k, 5));
            if (k == 30) chk(status == 8'h00, "R5 fill count not advanced", status, 8'h00);
        end
        chk(status == 8'h01, "R5 second buffer full at 32", status, 8'h01);
        busy_count(cnt);
        check_mem("R5 buffer contents intact", 160, 224, 5);
        wr(0, 16'hFFFF);
        tick();
        chk(status == 8'h80, "R9 exit from second block", status, 8'h80);

        // R8: verify mismatch.
        erase();
        bad_addr = 416 + 5;
        wc0 = wr_count;
        wr(416, 16'h0080); wr(416, 16'h00D0);
        for (int k = 0; k < 32; k++) wr(400, pat(416 + k, 8));
        busy_count(cnt);
        chk(cnt == 12, "R8 stop at failing word", cnt, 12);
        chk(status == 8'h10, "R8 exit with error", status, 8'h10);
        tick();
        chk(status == 8'h90, "R8 ready with error", status, 8'h90);
        chk(wr_count - wc0 == 6, "R8 no further writes", wr_count - wc0, 6);
        chk(mem[420] == pat(420, 8) && mem[422] == 16'hFFFF, "R8 array after abort",
            mem[422], 16'hFFFF);
        bad_addr = -1;
        wr(0, 16'h1234);
        chk(status == 8'h90, "R10 junk keeps error", status, 8'h90);
        wr(0, 16'h0050);
        chk(status == 8'h80, "R10 clear error", status, 8'h80);
        wc0 = wr_count;
        wr(0, 16'h0D0D);
        tick();
        chk(status == 8'h80 && wr_count == wc0, "R10 junk ignored", status, 8'h80);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule